// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block moves outgoing frame data from memory onto a byte stream. Software builds a ring of 8-byte descriptors, sets the ring base and raises a transmit-demand strobe. While the controller enable input is high, a demand starts a walk.

The walker fetches each descriptor through a 32-bit memory request port. If the descriptor is owned by hardware, the walker reads the buffer it points to and sends the bytes out one at a time. It then hands the descriptor back to software by clearing the ready flag in memory, and steps to the next descriptor. A frame may span several descriptors. The walk stops at the first descriptor that is not ready and keeps its position for the next demand.

One-cycle event pulses report each consumed buffer, each finished frame and each frame that was cut short at the size limit. An interrupt block downstream turns these pulses into interrupts.

Top module: `tx_ring_walker`

## Requirements
- R1: After reset, mem_req, tx_valid, ev_buf, ev_frame and ev_babble are all low.
- R2: A demand pulse while ctl_enable is low is ignored: no memory access is made and no byte is sent, and descriptors stay as they were.
- R3: The memory is big-endian. The 32-bit word at a descriptor's address holds {flags[15:0], length[15:0]}, and the word at address+4 holds the buffer byte address. Flag bit 15 means ready, bit 13 means wrap and bit 11 means last-of-frame. A walk ends at the first fetched descriptor whose ready bit is 0, and the next demand starts from that same descriptor.
- R4: Buffer bytes are sent in ascending address order, and a buffer may start at any byte address. Byte offset 0 of a word is bits 31:24 and offset 3 is bits 7:0.
- R5: tx_last is high only with the final byte sent from a descriptor whose last flag is set.
- R6: Once a buffer is finished, the descriptor's first word is written back with bit 31 (the ready flag) cleared and all other bits unchanged. ev_buf pulses for one cycle at that point, and ev_frame pulses with it when the last flag is set.
- R7: After a descriptor, the next one is read from the ring base if the wrap flag is set, and from the current address plus 8 otherwise.
- R8: A frame carries at most MAX_FRAME bytes. Bytes past the limit are not read or sent, and ev_babble pulses once, when the descriptor that crosses the limit is fetched. The byte count restarts after each last-of-frame descriptor.
- R9: Writing the ring base forces its two low bits to zero and also loads the current descriptor pointer.
- R10: A demand that arrives during a walk is remembered. When the walk ends at a not-ready descriptor, that descriptor is fetched once more.
- R11: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values.
- R12: mem_req, mem_addr and mem_we hold until mem_ack, and every memory address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_enable | input | 1 | Controller enable (bit 1 of the control register) |
| demand | input | 1 | Transmit-demand strobe |
| base_wr | input | 1 | Ring base write strobe |
| base_wdata | input | AW | Ring base value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Stream sink accepts the byte |
| ev_buf | output | 1 | Buffer consumed pulse |
| ev_frame | output | 1 | Frame finished pulse |
| ev_babble | output | 1 | Frame truncated pulse |

## Verification
The assertions watch the properties that must hold on every cycle. The stream and memory handshakes must stay stable while stalled, and every address must be word aligned. A written-back word must never carry the ready flag, a frame pulse must come with a buffer pulse, the frame byte count must stay within the limit, and a disabled idle walker must stay idle.

Some behaviour only the directed scenarios can show. These scenarios check the byte order across unaligned and chained buffers, the wrap back to the ring base, and the pointer kept between demands. They also check the truncation point with its single babble pulse, the masking of the base address, and the extra fetch caused by a demand held during a walk.

// File: rtl/tx_ring_walker.sv
module tx_ring_walker #(
  parameter int MAX_FRAME = 2032,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_enable,
  input  logic          demand,
  input  logic          base_wr,
  input  logic [AW-1:0] base_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic          ev_buf,
  output logic          ev_frame,
  output logic          ev_babble
);
  localparam int CW = $clog2(MAX_FRAME + 1);
  localparam int DESC_STEP = 8;
  localparam int WRAP_BIT = 13;
  localparam int LAST_BIT = 11;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_PTR, S_WORD, S_BYTE, S_WB} st_t;
  st_t st;

  logic [AW-1:0] ring_base, desc_ptr, buf_ptr;
  logic [15:0]   d_flags, d_len, left;
  logic [CW-1:0] fcnt;
  logic [31:0]   word;
  logic          pend;

  wire go = demand & ctl_enable;
  wire [15:0] room = 16'(MAX_FRAME) - 16'(fcnt);
  wire over = d_len > room;
  wire [15:0] take = over ? room : d_len;
  wire [AW-1:0] next_desc = d_flags[WRAP_BIT] ? ring_base : desc_ptr + AW'(DESC_STEP);
  wire xfer = tx_valid & tx_ready;

  assign mem_req  = (st == S_HDR) || (st == S_PTR) || (st == S_WORD) || (st == S_WB);
  assign mem_we   = (st == S_WB);
  assign mem_addr = (st == S_PTR)  ? desc_ptr + AW'(4) :
                    (st == S_WORD) ? {buf_ptr[AW-1:2], 2'b00} : desc_ptr;
  assign mem_wdata = {1'b0, d_flags[14:0], d_len};
  assign tx_valid = (st == S_BYTE);
  assign tx_last  = tx_valid & d_flags[LAST_BIT] & (left == 16'd1);

  always_comb begin
    case (buf_ptr[1:0])
      2'd0:    tx_data = word[31:24];
      2'd1:    tx_data = word[23:16];
      2'd2:    tx_data = word[15:8];
      default: tx_data = word[7:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ring_base <= '0;
      desc_ptr  <= '0;
      buf_ptr   <= '0;
      d_flags   <= '0;
      d_len     <= '0;
      left      <= '0;
      fcnt      <= '0;
      word      <= '0;
      pend      <= 1'b0;
      ev_buf    <= 1'b0;
      ev_frame  <= 1'b0;
      ev_babble <= 1'b0;
    end else begin
      ev_buf    <= 1'b0;
      ev_frame  <= 1'b0;
      ev_babble <= 1'b0;
      if (go && st != S_IDLE) pend <= 1'b1;
      case (st)
        S_IDLE: if (go) st <= S_HDR;
        S_HDR: if (mem_ack) begin
          d_flags <= mem_rdata[31:16];
          d_len   <= mem_rdata[15:0];
          if (mem_rdata[31]) st <= S_PTR;
          else if (pend || go) begin
            pend <= 1'b0;
            st   <= S_HDR;
          end else st <= S_IDLE;
        end
        S_PTR: if (mem_ack) begin
          buf_ptr <= mem_rdata[AW-1:0];
          left    <= take;
          if (over) ev_babble <= 1'b1;
          st <= (take == 16'd0) ? S_WB : S_WORD;
        end
        S_WORD: if (mem_ack) begin
          word <= mem_rdata;
          st   <= S_BYTE;
        end
        S_BYTE: if (xfer) begin
          buf_ptr <= buf_ptr + AW'(1);
          left    <= left - 16'd1;
          fcnt    <= fcnt + CW'(1);
          if (left == 16'd1) st <= S_WB;
          else if (buf_ptr[1:0] == 2'd3) st <= S_WORD;
        end
        S_WB: if (mem_ack) begin
          ev_buf <= 1'b1;
          if (d_flags[LAST_BIT]) begin
            ev_frame <= 1'b1;
            fcnt     <= '0;
          end
          desc_ptr <= next_desc;
          st <= S_HDR;
        end
        default: st <= S_IDLE;
      endcase
      if (base_wr) begin
        ring_base <= base_wdata & ~AW'(3);
        desc_ptr  <= base_wdata & ~AW'(3);
      end
    end
  end

  a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !base_wr |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  a_r12_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
  a_r11_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  a_r6_wb_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]);
  a_r6_frame_with_buf: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame |-> ev_buf);
  a_r8_frame_cap: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fcnt) <= MAX_FRAME);
  a_r2_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && !ctl_enable |=> !mem_req && !tx_valid);
endmodule

// File: tb/tx_ring_walker_tb.sv
`timescale 1ns/1ps
module tx_ring_walker_tb;
  logic clk = 0, rst_n = 0;
  logic ctl_enable = 0, demand = 0, base_wr = 0;
  logic [31:0] base_wdata = 0;
  logic mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [7:0] tx_data;
  logic tx_valid, tx_last, tx_ready = 1;
  logic ev_buf, ev_frame, ev_babble;

  tx_ring_walker #(.MAX_FRAME(20), .AW(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .demand(demand),
    .base_wr(base_wr), .base_wdata(base_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
    .ev_buf(ev_buf), .ev_frame(ev_frame), .ev_babble(ev_babble));

  always #10 clk = ~clk;

  logic [31:0] mem [0:255];
  int checks = 0, fails = 0;
  int lat = 0, wait_cnt = 0, acc_cnt = 0, misaligned = 0, watch_rd = 0;
  logic [31:0] watch_addr = 32'hFFFF_FFFF;
  bit stall = 0;
  int cyc = 0, n = 0, nbuf = 0, nframe = 0, nbab = 0;
  logic [7:0] got [0:63];
  logic gotlast [0:63];
  logic [7:0] expd [0:63];
  int nexp = 0;

  always @(negedge clk) begin
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      if (wait_cnt >= lat) begin
        wait_cnt = 0;
        mem_ack = 1;
        acc_cnt++;
        if (mem_addr[1:0] != 2'b00) misaligned++;
        if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
        else begin
          mem_rdata = mem[mem_addr[9:2]];
          if (mem_addr == watch_addr) watch_rd++;
        end
      end else wait_cnt++;
    end
  end

  always @(negedge clk) begin
    cyc++;
    tx_ready = stall ? (cyc % 3 != 0) : 1'b1;
    #1;
    if (tx_valid && tx_ready && n < 64) begin
      got[n] = tx_data;
      gotlast[n] = tx_last;
      n++;
    end
    if (ev_buf) nbuf++;
    if (ev_frame) nframe++;
    if (ev_babble) nbab++;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    n = 0; nbuf = 0; nframe = 0; nbab = 0; acc_cnt = 0; watch_rd = 0; nexp = 0;
  endtask

  task automatic put_desc(int a, logic [15:0] fl, logic [15:0] len, logic [31:0] b);
    mem[a >> 2] = {fl, len};
    mem[(a >> 2) + 1] = b;
  endtask

  task automatic put_byte(int a, logic [7:0] v);
    mem[a >> 2][(3 - (a % 4)) * 8 +: 8] = v;
  endtask

  task automatic add_exp(int a);
    expd[nexp] = mem[a >> 2][(3 - (a % 4)) * 8 +: 8];
    nexp++;
  endtask

  task automatic set_base(logic [31:0] v);
    @(negedge clk); base_wr = 1; base_wdata = v;
    @(negedge clk); base_wr = 0;
  endtask

  task automatic pulse_demand();
    @(negedge clk); demand = 1;
    @(negedge clk); demand = 0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 30) begin
      @(negedge clk); #2;
      if (!mem_req && !tx_valid) q++; else q = 0;
    end
  endtask

  task automatic chk_stream(string req);
    int bad = 0, lastpos = -1, nl = 0;
    chk({req, " byte count"}, n, nexp);
    for (int i = 0; i < nexp && i < n; i++) begin
      if (got[i] !== expd[i]) begin
        bad++;
        $display("FAIL %s byte %0d actual=%02h expected=%02h", req, i, got[i], expd[i]);
      end
      if (gotlast[i]) begin nl++; lastpos = i; end
    end
    checks++;
    if (bad != 0) fails++;
    chk({req, " last flags"}, nl, 1);
    chk({req, " last position"}, lastpos, nexp - 1);
  endtask

  task automatic t_reset();
    chk("R1 mem_req", int'(mem_req), 0);
    chk("R1 tx_valid", int'(tx_valid), 0);
    chk("R1 events", int'(ev_buf | ev_frame | ev_babble), 0);
  endtask

  task automatic t_disabled();
    clear_counts();
    ctl_enable = 0;
    put_desc(32'h000, 16'h8800, 16'd5, 32'h200);
    for (int i = 0; i < 5; i++) put_byte(32'h200 + i, 8'hA0 + 8'(i));
    set_base(32'h000);
    pulse_demand();
    repeat (20) @(negedge clk);
    chk("R2 no memory access", acc_cnt, 0);
    chk("R2 no bytes", n, 0);
    chk("R2 descriptor untouched", int'(mem[0][31]), 1);
  endtask

  task automatic t_single();
    clear_counts();
    ctl_enable = 1;
    watch_addr = 32'h008;
    for (int i = 0; i < 5; i++) add_exp(32'h200 + i);
    pulse_demand();
    wait_quiet();
    chk_stream("R4 R5 single");
    chk("R6 writeback word", int'(mem[0]), 32'h0800_0005);
    chk("R6 ev_buf", nbuf, 1);
    chk("R6 ev_frame", nframe, 1);
    chk("R3 stop at not-ready", watch_rd, 1);
    clear_counts();
    put_desc(32'h008, 16'h8800, 16'd1, 32'h240);
    put_byte(32'h240, 8'h5A);
    add_exp(32'h240);
    pulse_demand();
    wait_quiet();
    chk_stream("R3 pointer kept");
    chk("R3 second descriptor consumed", int'(mem[2][31]), 0);
  endtask

  task automatic t_chain();
    clear_counts();
    stall = 1; lat = 2;
    put_desc(32'h010, 16'h8000, 16'd3, 32'h203);
    put_desc(32'h018, 16'h8800, 16'd4, 32'h261);
    put_desc(32'h020, 16'h0000, 16'd0, 32'h0);
    put_byte(32'h203, 8'h11); put_byte(32'h204, 8'h22); put_byte(32'h205, 8'h33);
    for (int i = 0; i < 4; i++) put_byte(32'h261 + i, 8'h44 + 8'(i * 17));
    for (int i = 0; i < 3; i++) add_exp(32'h203 + i);
    for (int i = 0; i < 4; i++) add_exp(32'h261 + i);
    pulse_demand();
    wait_quiet();
    chk_stream("R4 R11 chained unaligned");
    chk("R6 two buffers", nbuf, 2);
    chk("R5 one frame", nframe, 1);
    stall = 0; lat = 0;
  endtask

  task automatic t_wrap();
    clear_counts();
    set_base(32'h100);
    put_desc(32'h100, 16'h8800, 16'd2, 32'h280);
    put_desc(32'h108, 16'hA800, 16'd2, 32'h284);
    put_desc(32'h110, 16'h8800, 16'd2, 32'h288);
    for (int i = 0; i < 12; i++) put_byte(32'h280 + i, 8'hC0 + 8'(i));
    add_exp(32'h280); add_exp(32'h281);
    watch_addr = 32'h100;
    pulse_demand();
    wait_quiet();
    chk("R7 bytes", n, 4);
    chk("R7 frames", nframe, 2);
    chk("R7 after-wrap slot untouched", int'(mem[32'h110 >> 2][31]), 1);
    chk("R7 base refetched", watch_rd, 2);
    chk("R7 second frame first byte", int'(got[2]), 32'hC4);
  endtask

  task automatic t_base_mask();
    clear_counts();
    misaligned = 0;
    set_base(32'h30A);
    put_desc(32'h308, 16'h8800, 16'd1, 32'h2C0);
    put_desc(32'h310, 16'h0000, 16'd0, 32'h0);
    put_byte(32'h2C0, 8'h77);
    add_exp(32'h2C0);
    pulse_demand();
    wait_quiet();
    chk_stream("R9 masked base");
    chk("R9 descriptor consumed", int'(mem[32'h308 >> 2][31]), 0);
    chk("R12 R9 aligned addresses", misaligned, 0);
  endtask

  task automatic t_trunc();
    clear_counts();
    set_base(32'h380);
    put_desc(32'h380, 16'h8000, 16'd12, 32'h340);
    put_desc(32'h388, 16'h8800, 16'd12, 32'h350);
    put_desc(32'h390, 16'h8800, 16'd3, 32'h340);
    put_desc(32'h398, 16'h0000, 16'd0, 32'h0);
    for (int i = 0; i < 28; i++) put_byte(32'h340 + i, 8'h10 + 8'(i));
    for (int i = 0; i < 12; i++) add_exp(32'h340 + i);
    for (int i = 0; i < 8; i++) add_exp(32'h350 + i);
    for (int i = 0; i < 3; i++) add_exp(32'h340 + i);
    pulse_demand();
    wait_quiet();
    chk("R8 total bytes", n, 23);
    chk("R8 babble once", nbab, 1);
    chk("R8 last at limit", int'(gotlast[19]), 1);
    chk("R8 byte before limit", int'(got[19]), int'(expd[19]));
    chk("R8 count restarts", int'(got[20]), int'(expd[20]));
    chk("R8 frames", nframe, 2);
  endtask

  task automatic t_pending();
    clear_counts();
    set_base(32'h000);
    put_desc(32'h000, 16'h8800, 16'd8, 32'h2C0);
    for (int i = 0; i < 8; i++) put_byte(32'h2C0 + i, 8'hE0 + 8'(i));
    watch_addr = 32'h008;
    lat = 3; stall = 1;
    pulse_demand();
    repeat (6) @(negedge clk);
    pulse_demand();
    wait_quiet();
    chk("R10 stop descriptor fetched twice", watch_rd, 2);
    chk("R10 bytes", n, 8);
    chk("R10 buffers", nbuf, 1);
    lat = 0; stall = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (5) @(negedge clk);
    #3;
    t_reset();
    rst_n = 1;
    t_disabled();
    t_single();
    t_chain();
    t_wrap();
    t_base_mask();
    t_trunc();
    t_pending();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule